// File: doc/BRIEF.md
# Field-Aligned Input Cropper

This block sits on the core clock directly after the input FIFO. It takes a 4:2:2 pixel stream that carries separate vertical and horizontal sync markers and a pixel valid. It does two things. First, it keeps the downstream processing in reset until a whole field can be delivered, so that processing always begins at the first pixel of the first line of a field. Second, it crops every field to one of three output sizes by dropping pixels at the right of each line and lines at the bottom of each field. It does no interpolation.

After the enable is raised, video that is already in flight is thrown away. The next vertical sync seen while the block is enabled releases the downstream logic, and that sync is forwarded along with the rest of the field. The size select is captured only on a vertical sync, so a field is never cropped to two different sizes.

A sync marker cycle carries no pixel. The first horizontal sync after a vertical sync opens line 0. Each cycle with valid high and no sync marker is one pixel, counted from 0 after each horizontal sync.

Top module: `vid_crop_sync`

## Requirements
- R1: While `rst_n` is low, `proc_run`, `out_valid`, `out_vsync`, `out_hsync` and `out_data` are all 0, whatever the inputs do.
- R2: After `rst_n` is released, and whenever `enable` has just risen, `proc_run` stays 0 and no pixel is output until a cycle in which `in_vsync` and `enable` are both high. `proc_run` rises on the same clock edge that presents that sync on `out_vsync`, one cycle after the input sync.
- R3: While running, every forwarded output (`out_vsync`, `out_hsync`, `out_valid`, `out_data`) is the registered image of its input, one cycle late.
- R4: Horizontal crop. A pixel is kept only if its index within the line is below the width for the captured size code: 00 = full D1 width (`W_FULL`, 720), 01 = `W_TRIM` (704), 10 = `W_NARROW` (640). A pixel at or beyond `W_FULL` is always dropped.
- R5: Vertical crop. A line is kept only if its index within the field is below `H_FULL` (288) for codes 00, 01 and 11, or below `H_NARROW` (240) for code 10. On a 525-line source, with 240 active lines per field, codes 00 and 01 therefore pass every line.
- R6: The size code is sampled on `in_vsync` cycles only. A change of `size_sel` in the middle of a field has no effect until the next field.
- R7: Code 11 crops exactly like code 00.
- R8: `in_valid` is ignored on a cycle that carries `in_vsync` or `in_hsync`, and on any cycle after a vertical sync but before the first horizontal sync of that field.
- R9: When `enable` goes low, `proc_run` and all forwarded outputs fall one cycle later. When `enable` is raised again, the block waits for the next vertical sync as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset for the whole block |
| enable | input | 1 | Allows processing to start at the next field |
| size_sel | input | 2 | Output size code: 00 D1, 01 4CIF, 10 VGA, 11 D1 |
| in_vsync | input | 1 | Field start marker, one cycle |
| in_hsync | input | 1 | Line start marker, one cycle |
| in_valid | input | 1 | Pixel present on `in_data` |
| in_data | input | DATA_W | Pixel sample |
| out_vsync | output | 1 | Forwarded field start marker |
| out_hsync | output | 1 | Forwarded line start marker |
| out_valid | output | 1 | Cropped pixel present on `out_data` |
| out_data | output | DATA_W | Cropped pixel sample, 0 when not valid |
| proc_run | output | 1 | High when downstream processing is released from reset |

## Verification
Every forwarded output is due exactly one edge after its input cycle, and `proc_run` changes on that same edge. The bench therefore drives inputs just after a rising edge and samples on the falling edge that follows the next rising edge. The check on the start sync looks at `out_vsync` and `proc_run` together in that cycle. The pixel monitor compares each valid output with the next position in a raster that the bench expects. At the end of each field, after two idle cycles have let the pipeline drain, the bench compares the number of kept pixels with the cropped width times the cropped height, worked out from the size code that was in force at that field's sync.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

  typedef enum logic [1:0] {
    SZ_FULL   = 2'b00,
    SZ_TRIM   = 2'b01,
    SZ_NARROW = 2'b10,
    SZ_SPARE  = 2'b11
  } size_e;

  typedef enum logic {
    G_HOLD = 1'b0,
    G_RUN  = 1'b1
  } gate_e;

  // pixels kept per line for a size code
  function automatic int unsigned keep_width(size_e s, int unsigned w_full,
                                             int unsigned w_trim, int unsigned w_narrow);
    case (s)
      SZ_TRIM:   return w_trim;
      SZ_NARROW: return w_narrow;
      default:   return w_full;
    endcase
  endfunction

  // lines kept per field for a size code
  function automatic int unsigned keep_height(size_e s, int unsigned h_full,
                                              int unsigned h_narrow);
    return (s == SZ_NARROW) ? h_narrow : h_full;
  endfunction

endpackage

// File: rtl/vcs_start_gate.sv
module vcs_start_gate
  import vcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic in_vsync,
  output logic pass,
  output logic run_o
);

  gate_e state, state_nx;

  always_comb begin
    state_nx = state;
    if (!enable)                            state_nx = G_HOLD;
    else if (state == G_HOLD && in_vsync)   state_nx = G_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= G_HOLD;
    else        state <= state_nx;
  end

  assign run_o = (state == G_RUN);
  // the releasing sync itself is forwarded
  assign pass  = enable && (run_o || in_vsync);

  AST_START_ON_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> $past(in_vsync));  // R2
  AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !run_o);  // R9

endmodule

// File: rtl/vcs_raster_crop.sv
module vcs_raster_crop
  import vcs_pkg::*;
#(
  parameter int unsigned W_FULL   = 720,
  parameter int unsigned W_TRIM   = 704,
  parameter int unsigned W_NARROW = 640,
  parameter int unsigned H_FULL   = 288,
  parameter int unsigned H_NARROW = 240
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] size_sel,
  input  logic       in_vsync,
  input  logic       in_hsync,
  input  logic       in_valid,
  output logic       keep
);

  localparam int unsigned PW = $clog2(W_FULL + 1);
  localparam int unsigned LW = $clog2(H_FULL + 1);

  size_e          sel_q;
  logic [PW-1:0]  pix_cnt;
  logic [LW-1:0]  line_cnt;
  logic           in_line;
  logic [PW-1:0]  w_lim;
  logic [LW-1:0]  h_lim;
  logic           is_pix;

  assign w_lim  = PW'(keep_width(sel_q, W_FULL, W_TRIM, W_NARROW));
  assign h_lim  = LW'(keep_height(sel_q, H_FULL, H_NARROW));
  assign is_pix = in_valid && !in_vsync && !in_hsync;
  assign keep   = is_pix && in_line && (pix_cnt < w_lim) && (line_cnt < h_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= SZ_FULL;
      pix_cnt  <= '0;
      line_cnt <= '0;
      in_line  <= 1'b0;
    end else if (in_vsync) begin
      sel_q    <= size_e'(size_sel);
      pix_cnt  <= '0;
      line_cnt <= '0;
      in_line  <= 1'b0;
    end else if (in_hsync) begin
      pix_cnt <= '0;
      in_line <= 1'b1;
      if (in_line && line_cnt != LW'(H_FULL)) line_cnt <= line_cnt + 1'b1;
    end else if (is_pix && pix_cnt != PW'(W_FULL)) begin
      pix_cnt <= pix_cnt + 1'b1;
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vsync |=> $stable(sel_q));  // R6
  AST_NO_PIX_BEFORE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vsync) |-> !keep);  // R8

endmodule

// File: rtl/vcs_out_stage.sv
module vcs_out_stage #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass,
  input  logic              keep,
  input  logic              in_vsync,
  input  logic              in_hsync,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vsync,
  output logic              out_hsync,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic take;
  assign take = pass && keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vsync <= 1'b0;
      out_hsync <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_vsync <= pass && in_vsync;
      out_hsync <= pass && in_hsync && !in_vsync;
      out_valid <= take;
      out_data  <= take ? in_data : '0;
    end
  end

endmodule

// File: rtl/vid_crop_sync.sv
module vid_crop_sync #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned W_FULL   = 720,
  parameter int unsigned W_TRIM   = 704,
  parameter int unsigned W_NARROW = 640,
  parameter int unsigned H_FULL   = 288,
  parameter int unsigned H_NARROW = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        size_sel,
  input  logic              in_vsync,
  input  logic              in_hsync,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vsync,
  output logic              out_hsync,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              proc_run
);

  logic pass;
  logic keep;

  vcs_start_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .in_vsync (in_vsync),
    .pass     (pass),
    .run_o    (proc_run)
  );

  vcs_raster_crop #(
    .W_FULL   (W_FULL),
    .W_TRIM   (W_TRIM),
    .W_NARROW (W_NARROW),
    .H_FULL   (H_FULL),
    .H_NARROW (H_NARROW)
  ) u_crop (
    .clk      (clk),
    .rst_n    (rst_n),
    .size_sel (size_sel),
    .in_vsync (in_vsync),
    .in_hsync (in_hsync),
    .in_valid (in_valid),
    .keep     (keep)
  );

  vcs_out_stage #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pass      (pass),
    .keep      (keep),
    .in_vsync  (in_vsync),
    .in_hsync  (in_hsync),
    .in_data   (in_data),
    .out_vsync (out_vsync),
    .out_hsync (out_hsync),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  AST_VALID_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> proc_run);  // R2
  AST_SYNC_NO_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vsync || out_hsync) |-> !out_valid);  // R8
  AST_STOP_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !out_valid && !out_vsync);  // R9

endmodule

// File: tb/vid_crop_sync_tb.sv
module vid_crop_sync_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int WF  = 12;
  localparam int WT  = 10;
  localparam int WN  = 8;
  localparam int HF  = 6;
  localparam int HN  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [1:0]    size_sel = 2'b00;
  logic          in_vsync = 1'b0;
  logic          in_hsync = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_vsync, out_hsync, out_valid, proc_run;
  logic [DW-1:0] out_data;

  vid_crop_sync #(
    .DATA_W(DW), .W_FULL(WF), .W_TRIM(WT), .W_NARROW(WN), .H_FULL(HF), .H_NARROW(HN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .size_sel(size_sel),
    .in_vsync(in_vsync), .in_hsync(in_hsync), .in_valid(in_valid), .in_data(in_data),
    .out_vsync(out_vsync), .out_hsync(out_hsync), .out_valid(out_valid),
    .out_data(out_data), .proc_run(proc_run)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // monitor state
  bit expect_out = 1'b0;
  int vs_sel = 0, vs_np = 0;
  int cur_w = 0, nl = 0, np = 0, got = 0;
  int chg_line = -1, chg_val = 0, drop_line = -1;

  function automatic int ew(int s);
    if (s == 1) return WT;
    if (s == 2) return WN;
    return WF;
  endfunction
  function automatic int eh(int s);
    return (s == 2) ? HN : HF;
  endfunction
  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        chk(proc_run == 1'b1, "R2 pixel while held", int'(proc_run), 1);
        chk(expect_out, "R9 pixel while not expected", 1, 0);
        chk(out_data == DW'(nl * 16 + np), "R4 R5 pixel order", int'(out_data), nl * 16 + np);
        np++;
        if (np == cur_w) begin np = 0; nl++; end
        got++;
      end
      if (out_vsync) begin
        got = 0; nl = 0; np = 0;
        cur_w = imin(ew(vs_sel), vs_np);
      end
    end
  end

  task automatic cyc(bit v, bit h, bit val, logic [DW-1:0] d);
    @(posedge clk); #1;
    in_vsync = v; in_hsync = h; in_valid = val; in_data = d;
  endtask

  task automatic send_field(bit with_vs, int nls, int nps, bit dirty, bit exp_vs,
                            int exp_total, string req);
    got = 0;
    if (with_vs) begin
      vs_sel = int'(size_sel);
      vs_np  = nps;
      cyc(1'b1, 1'b0, dirty, 8'hEE);
      cyc(1'b0, 1'b0, 1'b0, '0);
      @(negedge clk);
      chk(out_vsync == exp_vs, "R3 vsync one cycle late", int'(out_vsync), int'(exp_vs));
      chk(proc_run == exp_vs, "R2 release with forwarded vsync", int'(proc_run), int'(exp_vs));
      if (dirty) for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b1, 8'hF0);
    end
    for (int l = 0; l < nls; l++) begin
      if (l == chg_line) size_sel = 2'(chg_val);
      if (l == drop_line) begin enable = 1'b0; expect_out = 1'b0; end
      cyc(1'b0, 1'b1, dirty, 8'hDD);
      cyc(1'b0, 1'b0, 1'b0, '0);
      for (int p = 0; p < nps; p++) begin
        cyc(1'b0, 1'b0, 1'b1, DW'(l * 16 + p));
        if (p == 3) cyc(1'b0, 1'b0, 1'b0, '0);
      end
      cyc(1'b0, 1'b0, 1'b0, '0);
    end
    cyc(1'b0, 1'b0, 1'b0, '0);
    cyc(1'b0, 1'b0, 1'b0, '0);
    @(negedge clk);
    chk(got == exp_total, req, got, exp_total);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: busy inputs during reset
    enable = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc(k == 0, k == 1, 1'b1, 8'h55);
      @(negedge clk);
      chk(!proc_run && !out_valid && !out_vsync && !out_hsync && out_data == '0,
          "R1 outputs quiet in reset", int'(out_valid), 0);
    end
    enable = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, '0);
    rst_n = 1'b1;

    // disabled: nothing released
    send_field(1'b1, 3, 5, 1'b0, 1'b0, 0, "R2 no output while disabled");
    chk(proc_run == 1'b0, "R2 held while disabled", int'(proc_run), 0);

    // enabled mid-field: rest of field discarded
    enable = 1'b1;
    send_field(1'b0, 3, 14, 1'b0, 1'b0, 0, "R2 mid-field video dropped");
    chk(proc_run == 1'b0, "R2 waits for vsync", int'(proc_run), 0);

    // size sweep, 7 lines x 14 pixels source
    expect_out = 1'b1;
    size_sel = 2'b00; send_field(1'b1, 7, 14, 1'b0, 1'b1, WF * HF, "R4 R5 full size");
    size_sel = 2'b01; send_field(1'b1, 7, 14, 1'b0, 1'b1, WT * HF, "R4 R5 trim size");
    size_sel = 2'b10; send_field(1'b1, 7, 14, 1'b0, 1'b1, WN * HN, "R4 R5 narrow size");
    size_sel = 2'b11; send_field(1'b1, 7, 14, 1'b0, 1'b1, WF * HF, "R7 spare code as full");
    size_sel = 2'b00; send_field(1'b1, 3, 5, 1'b0, 1'b1, 15, "R4 R5 short source passes whole");

    // R6: mid-field change ignored, applied next field
    size_sel = 2'b10; chg_line = 2; chg_val = 0;
    send_field(1'b1, 7, 14, 1'b0, 1'b1, WN * HN, "R6 mid-field select ignored");
    chg_line = -1;
    send_field(1'b1, 7, 14, 1'b0, 1'b1, WF * HF, "R6 new select at next field");

    // R8: valid on sync cycles and before first line
    size_sel = 2'b01;
    send_field(1'b1, 7, 14, 1'b1, 1'b1, WT * HF, "R8 stray valid ignored");

    // R9: disable mid-field, then re-enable
    size_sel = 2'b00; drop_line = 2;
    send_field(1'b1, 7, 14, 1'b0, 1'b1, 2 * WF, "R9 output stops on disable");
    drop_line = -1;
    chk(proc_run == 1'b0, "R9 release dropped", int'(proc_run), 1'b0);
    enable = 1'b1;
    send_field(1'b0, 4, 14, 1'b0, 1'b0, 0, "R9 re-enable waits for vsync");
    chk(proc_run == 1'b0, "R9 still held before vsync", int'(proc_run), 0);
    expect_out = 1'b1;
    send_field(1'b1, 7, 14, 1'b0, 1'b1, WF * HF, "R9 restart at field");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule